// File: doc/BRIEF.md
# Tagged Sample Buffer with Byte-Wide Serial Readout

This block stores ADC samples while an acquisition window is open and returns them later, one byte per chip-select, over a serial peripheral link. A programmable divider sets the sample rate. With a 64 MHz system clock and an 8-bit divider setting `f`, one sample is taken every `f+1` clocks, which is 64/(1+f) MHz. Each stored word holds the 10-bit conversion, a 2-bit cycle index that tells lines of a sequence apart, and two auxiliary input bits.

Every stored word is read as two self-identifying bytes, the high byte first. While the window is open, each read returns a fixed busy marker, so the host can poll until the capture ends. The first read after a window closes returns a throw-away byte. A self-clearing pointer-reset pulse returns both the write and the read position to zero. The write side fills the buffer once and then stops. The read side wraps around the buffer. Reading beyond what was captured returns old contents and raises no flag.

The write side is a state machine with three states. `W_IDLE` is the state with no window open. `W_RUN` is capturing. `W_FULL` is entered when the last slot is written and is left only through pointer reset. The serial side is a second state machine with three states. `ST_IDLE` has select high. On the select-fall transition it moves to `ST_SHIFT`, where bits are shifted out. On the select-rise transition it moves to `ST_COMMIT`, which lasts one cycle and updates the pointers, and then returns to `ST_IDLE` unconditionally.

Top module: `smpl_spi_buf`

## Requirements
- R1: After reset both pointers and the byte phase are zero and all buffer words are zero, so the first read returns 0x80 and the second read returns 0x00.
- R2: While `acq_active` is high when a transaction starts, that transaction returns 0xAA and leaves the read position and byte phase unchanged.
- R3: While `acq_active` is high, a sample is written on every clock edge whose 1-based count since the window opened is a multiple of `div_f+1`. Samples are written in order at consecutive buffer slots.
- R4: The high byte is {1, cycle[1:0], aux[1:0], adc[9:7]}, with bit 7 always 1.
- R5: The low byte is {0, adc[6:0]}, with bit 7 always 0.
- R6: The high byte of a sample is returned before its low byte. The read position advances by one sample only after the low byte has been sent.
- R7: Once DEPTH samples are stored, further sample ticks are dropped and earlier contents are kept until pointer reset.
- R8: A `ptr_clear` pulse sets the write count, the read position and the byte phase to zero. It leaves stored words in place.
- R9: The first complete transaction after `acq_active` falls returns 0x00 and consumes nothing.
- R10: Reads beyond the written samples return the stored contents at that slot. The read position wraps modulo DEPTH, which must be a power of two.
- R11: A transaction with other than exactly eight SCLK rising edges has no effect on the read position, the byte phase or the pending throw-away byte.
- R12: The byte is chosen when select falls, and its bit 7 is on MISO before the first SCLK rise. Bits go out MSB first and change after SCLK falling edges (mode 0). MISO is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (64 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_active | input | 1 | High during the acquisition window |
| ptr_clear | input | 1 | One-cycle pointer-reset command |
| div_f | input | 8 | Sample divider; period is div_f+1 clocks |
| cycle_idx | input | 2 | Cycle tag stored with each sample |
| aux_in | input | 2 | Auxiliary bits stored with each sample |
| adc_data | input | 10 | ADC conversion result |
| spi_sclk | input | 1 | Serial clock from host (asynchronous) |
| spi_cs_n | input | 1 | Active-low select from host (asynchronous) |
| spi_miso | output | 1 | Serial data to host |

## Verification
The bench sweeps the divider setting and the window length, including an overflowing window. It computes which clock edges take a sample and the byte that each read must return. A divider that is off by one clock shifts every captured value, and a write counter that does not stop at the buffer end overwrites slot 0, which the wrap-around read exposes. The bench also checks that a read started during capture, a truncated four-bit transaction and the throw-away byte after capture consume nothing. A design that advanced on any of these would skip a byte or return a low byte where a high byte belongs. A pointer reset issued between the two bytes of a sample must restart at a high byte, and one that kept the phase would return the wrong half.

// File: rtl/smpl_spi_pkg.sv
package smpl_spi_pkg;

    localparam int ADC_W  = 10;
    localparam int TAG_W  = 2;
    localparam int WORD_W = 2 * TAG_W + ADC_W;

    localparam logic [7:0] BUSY_BYTE  = 8'hAA;
    localparam logic [7:0] DUMMY_BYTE = 8'h00;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_RUN  = 2'd1,
        W_FULL = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } spi_state_e;

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_BUSY  = 2'd1,
        K_DUMMY = 2'd2
    } xfer_kind_e;

endpackage

// File: rtl/smpl_rate_div.sv
module smpl_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_f,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clear) begin
            cnt <= '0;
        end else if (cnt == div_f) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && !clear && (cnt == div_f);

endmodule

// File: rtl/smpl_store.sv
module smpl_store
    import smpl_spi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_active,
    input  logic              tick,
    input  logic              clear,
    input  logic [TAG_W-1:0]  cycle_idx,
    input  logic [TAG_W-1:0]  aux_in,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [AW:0]       wr_cnt
);

    wr_state_e         state, state_nx;
    logic [WORD_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic              last_slot;

    assign last_slot = (wr_cnt == AW'(DEPTH - 1));
    assign wr_en     = tick && !clear && (state != W_FULL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE: begin
                if (wr_en && last_slot) begin
                    state_nx = W_FULL;
                end else if (acq_active) begin
                    state_nx = W_RUN;
                end
            end
            W_RUN: begin
                if (wr_en && last_slot) begin
                    state_nx = W_FULL;
                end else if (!acq_active) begin
                    state_nx = W_IDLE;
                end
            end
            W_FULL: begin
                state_nx = W_FULL;
            end
            default: state_nx = W_IDLE;
        endcase
        if (clear) begin
            state_nx = W_IDLE;
        end
    end

    // write count and storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (clear) begin
            wr_cnt <= '0;
        end else if (wr_en) begin
            mem[wr_cnt[AW-1:0]] <= {cycle_idx, aux_in, adc_data};
            wr_cnt              <= wr_cnt + 1'b1;
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import smpl_spi_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_raw,
    input  logic              cs_n_raw,
    input  logic              acq_active,
    input  logic              acq_done,
    input  logic              clear,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     rd_idx,
    output logic              phase,
    output logic              commit,
    output xfer_kind_e        kind,
    output logic [3:0]        bit_cnt,
    output logic              miso
);

    spi_state_e state, state_nx;
    logic [2:0] sclk_q, cs_q;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic [7:0] tx_sr;
    logic [7:0] next_byte;
    xfer_kind_e next_kind;
    logic       dummy_pend;
    logic       full_xfer;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 3'b000;
            cs_q   <= 3'b111;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk_raw};
            cs_q   <= {cs_q[1:0], cs_n_raw};
        end
    end

    assign sclk_rise = sclk_q[1] && !sclk_q[2];
    assign sclk_fall = !sclk_q[1] && sclk_q[2];
    assign cs_fall   = !cs_q[1] && cs_q[2];
    assign cs_rise   = cs_q[1] && !cs_q[2];

    // byte selection at select fall
    always_comb begin
        if (acq_active) begin
            next_kind = K_BUSY;
            next_byte = BUSY_BYTE;
        end else if (dummy_pend) begin
            next_kind = K_DUMMY;
            next_byte = DUMMY_BYTE;
        end else if (phase) begin
            next_kind = K_DATA;
            next_byte = {1'b0, rd_word[6:0]};
        end else begin
            next_kind = K_DATA;
            next_byte = {1'b1, rd_word[WORD_W-1:7]};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            kind    <= K_DATA;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        tx_sr   <= next_byte;
                        kind    <= next_kind;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise && bit_cnt != 4'hF) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (sclk_fall) begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                end
                ST_COMMIT: begin
                    tx_sr <= tx_sr;
                end
                default: tx_sr <= tx_sr;
            endcase
        end
    end

    assign commit    = (state == ST_COMMIT);
    assign full_xfer = commit && (bit_cnt == 4'd8);
    assign miso      = (state == ST_SHIFT) ? tx_sr[7] : 1'b0;

    // read pointer and byte phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
            phase  <= 1'b0;
        end else if (clear) begin
            rd_idx <= '0;
            phase  <= 1'b0;
        end else if (full_xfer && kind == K_DATA) begin
            phase <= !phase;
            if (phase) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    // throw-away byte after a capture window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dummy_pend <= 1'b0;
        end else if (acq_done) begin
            dummy_pend <= 1'b1;
        end else if (full_xfer && kind == K_DUMMY) begin
            dummy_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/smpl_spi_buf.sv
module smpl_spi_buf
    import smpl_spi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_active,
    input  logic             ptr_clear,
    input  logic [DIV_W-1:0] div_f,
    input  logic [1:0]       cycle_idx,
    input  logic [1:0]       aux_in,
    input  logic [9:0]       adc_data,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    output logic             spi_miso
);

    logic              tick;
    logic              acq_q;
    logic              acq_done;
    logic [WORD_W-1:0] rd_word;
    logic [AW:0]       wr_cnt;
    logic [AW-1:0]     rd_idx;
    logic              phase;
    logic              commit;
    xfer_kind_e        kind;
    logic [3:0]        bit_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q <= 1'b0;
        end else begin
            acq_q <= acq_active;
        end
    end

    assign acq_done = acq_q && !acq_active;

    smpl_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (acq_active),
        .clear (ptr_clear),
        .div_f (div_f),
        .tick  (tick)
    );

    smpl_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_active (acq_active),
        .tick       (tick),
        .clear      (ptr_clear),
        .cycle_idx  (cycle_idx),
        .aux_in     (aux_in),
        .adc_data   (adc_data),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word),
        .wr_cnt     (wr_cnt)
    );

    spi_byte_port #(.AW(AW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_raw   (spi_sclk),
        .cs_n_raw   (spi_cs_n),
        .acq_active (acq_active),
        .acq_done   (acq_done),
        .clear      (ptr_clear),
        .rd_word    (rd_word),
        .rd_idx     (rd_idx),
        .phase      (phase),
        .commit     (commit),
        .kind       (kind),
        .bit_cnt    (bit_cnt),
        .miso       (spi_miso)
    );

endmodule

// File: rtl/smpl_spi_buf_chk.sv
module smpl_spi_buf_chk
    import smpl_spi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ptr_clear,
    input logic [AW:0]   wr_cnt,
    input logic [AW-1:0] rd_idx,
    input logic          phase,
    input logic          commit,
    input xfer_kind_e    kind,
    input logic [3:0]    bit_cnt
);

    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= (AW+1)'(DEPTH)); // R7

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt == (AW+1)'(DEPTH)) && !ptr_clear |=> wr_cnt == (AW+1)'(DEPTH)); // R7

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_clear |=> (wr_cnt == $past(wr_cnt)) || (wr_cnt == $past(wr_cnt) + 1'b1)); // R3

    AST_CLEAR_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> (wr_cnt == '0) && (rd_idx == '0) && !phase); // R8

    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (kind == K_BUSY) && !ptr_clear |=> $stable(rd_idx) && $stable(phase)); // R2

    AST_SHORT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (bit_cnt != 4'd8) && !ptr_clear |=> $stable(rd_idx) && $stable(phase)); // R11

    AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_clear && !phase |=> $stable(rd_idx)); // R6

endmodule

bind smpl_spi_buf smpl_spi_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_clear (ptr_clear),
    .wr_cnt    (wr_cnt),
    .rd_idx    (rd_idx),
    .phase     (phase),
    .commit    (commit),
    .kind      (kind),
    .bit_cnt   (bit_cnt)
);

// File: tb/sim_smpl_spi_buf.sv
`timescale 1ns/1ps
module sim_smpl_spi_buf;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq_active = 1'b0;
    logic       ptr_clear = 1'b0;
    logic [7:0] div_f = 8'd3;
    logic [1:0] cycle_idx = 2'd0;
    logic [1:0] aux_in = 2'd0;
    logic [9:0] adc_data = 10'd0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_miso;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [13:0] mem_m [DEPTH];
    int          wcnt_m = 0;
    int          rd_m   = 0;
    bit          ph_m   = 1'b0;

    always #2.5 clk = ~clk;

    smpl_spi_buf u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_active (acq_active),
        .ptr_clear  (ptr_clear),
        .div_f      (div_f),
        .cycle_idx  (cycle_idx),
        .aux_in     (aux_in),
        .adc_data   (adc_data),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_miso   (spi_miso)
    );

    function automatic logic [9:0] adc_of(int c);
        return 10'((c * 173 + 29) % 1024);
    endfunction

    function automatic logic [1:0] aux_of(int c);
        return 2'((c * 3) % 4);
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic spi_xfer(int nbits, output logic [7:0] b);
        b = 8'h00;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            b = {b[6:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk) ptr_clear = 1'b1;
        @(negedge clk) ptr_clear = 1'b0;
        wcnt_m = 0;
        rd_m   = 0;
        ph_m   = 1'b0;
    endtask

    // R3: sample k (1-based) taken at window edge k*(f+1)
    task automatic run_acq(int f, int len, logic [1:0] cyc);
        int n;
        div_f     = 8'(f);
        cycle_idx = cyc;
        for (int c = 1; c <= len; c++) begin
            @(negedge clk);
            acq_active = 1'b1;
            adc_data   = adc_of(c);
            aux_in     = aux_of(c);
        end
        @(negedge clk) acq_active = 1'b0;
        n = len / (f + 1);
        for (int k = 1; k <= n; k++) begin
            if (wcnt_m < DEPTH) begin
                mem_m[wcnt_m] = {cyc, aux_of(k * (f + 1)), adc_of(k * (f + 1))};
                wcnt_m++;
            end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic read_data(string req);
        logic [7:0] b, e;
        e = ph_m ? {1'b0, mem_m[rd_m][6:0]} : {1'b1, mem_m[rd_m][13:7]};
        spi_xfer(8, b);
        check(req, b, e);
        if (ph_m) rd_m = (rd_m + 1) % DEPTH;
        ph_m = !ph_m;
    endtask

    task automatic read_dummy();
        logic [7:0] b;
        spi_xfer(8, b);
        check("R9 throw-away byte", b, 8'h00);
    endtask

    task automatic sweep_run(int f, int len, logic [1:0] cyc);
        int n;
        pulse_clear();
        run_acq(f, len, cyc);
        n = wcnt_m;
        read_dummy();
        for (int s = 0; s < n; s++) begin
            read_data("R3/R4/R6 high byte");
            read_data("R3/R5/R6 low byte");
        end
        read_data("R10 past end or wrap");
    endtask

    initial begin
        logic [7:0] b;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        checks++;
        if (spi_miso !== 1'b0) begin
            fails++;
            $display("FAIL R12 idle miso got %0b expected 0", spi_miso);
        end
        // R1: cleared buffer reads as 0x80 then 0x00
        read_data("R1 reset high byte");
        read_data("R1 reset low byte");

        // sweeps over divider and window length; last one overflows (R7)
        sweep_run(0, 5, 2'd1);
        sweep_run(1, 9, 2'd2);
        sweep_run(3, 30, 2'd3);
        sweep_run(7, 50, 2'd0);
        sweep_run(2, 20, 2'd1);
        sweep_run(0, 40, 2'd2);
        read_data("R7 slot 0 kept after overflow low byte");

        // R11: short transaction, R8: clear between bytes
        pulse_clear();
        run_acq(1, 8, 2'd1);
        read_dummy();
        spi_xfer(4, b);
        check("R11 partial bits", b, {4'h0, 1'b1, mem_m[0][13:11]});
        read_data("R11 no advance high byte");
        read_data("R6 low byte");
        read_data("R6 next high byte");
        pulse_clear();
        read_data("R8 phase reset high byte");

        // R2: busy marker with no capture (divider longer than window)
        div_f = 8'd255;
        @(negedge clk) acq_active = 1'b1;
        spi_xfer(8, b);
        check("R2 busy marker", b, 8'hAA);
        @(negedge clk) acq_active = 1'b0;
        repeat (4) @(negedge clk);
        read_dummy();
        read_data("R2 no advance low byte");
        read_data("R6 following high byte");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule